// File: doc/BRIEF.md
# Video-Synchronous Memory Contention Generator

This block tracks the current T-state inside a video frame of 311 lines of 228 T-states, which is 70908 T-states per frame. It raises the frame interrupt at the start of each frame. When the processor begins an access to a memory bank that competes with the video fetch, the block reports how many wait T-states the access must be held for. The count depends on where the beam is inside the active part of the picture.

Two machine types are supported, chosen by `mode_i`. Each type has its own window start and width, and its own 8-step delay pattern. A one-T-state skew input moves the interrupt and the contention window one T-state later, to model units that run one T-state behind. The paging logic drives the contended flag. The clock enable marks each T-state.

Top module: `contention_gen`

## Requirements
- R1: After reset `tstate_o` and `line_o` are 0. Each cycle with `ce_i` high advances `tstate_o` by one. At 227 it wraps to 0 and `line_o` advances. At line 310 `line_o` wraps to 0, which gives a 70908-T-state frame.
- R2: In a cycle with `ce_i` low, `tstate_o` and `line_o` keep their values.
- R3: With `shift_i` low, `irq_o` is high while `line_o` is 0 and `tstate_o` is below 32, and low at every other position.
- R4: With `mode_i` = 0, for lines 63 to 254 and T-states 5 to 132, the delay is 6,5,4,3,2,1,0,0 indexed by (T-state − 5) mod 8.
- R5: With `mode_i` = 1, for lines 63 to 254 and T-states 9 to 138, the delay is 1,0,7,6,5,4,3,2 indexed by (T-state − 9) mod 8.
- R6: Outside the line and T-state window of the selected mode, `delay_o` is 0.
- R7: `delay_o` is 0 unless `req_i` and `contended_i` are both high.
- R8: With `shift_i` high, `irq_o` and `delay_o` take the values that the unshifted rules give for the position one T-state before the current counters. Position 0 maps to line 310, T-state 227. `tstate_o` and `line_o` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | One pulse per T-state |
| mode_i | input | 1 | Machine type: 0 earlier, 1 later |
| shift_i | input | 1 | Shifts all timings one T-state later |
| req_i | input | 1 | Processor access starts this T-state |
| contended_i | input | 1 | Addressed bank is contended |
| delay_o | output | 3 | Wait T-states to insert |
| irq_o | output | 1 | Frame interrupt |
| line_o | output | 9 | Current line in frame |
| tstate_o | output | 8 | Current T-state in line |

## Verification
The assertions assume that `shift_i` is steady around the frame start whenever the interrupt property is checked. That property is qualified with `shift_i` low. They also assume that `ce_i` is the only thing that advances the position. The bench sweeps more than a full frame in each mode. It drops `ce_i` for single cycles now and then, and changes `shift_i` only at the negative edge, so every combinational output settles before it is sampled.

// File: rtl/contention_pkg.sv
package contention_pkg;
  typedef enum logic {MACH_EARLY = 1'b0, MACH_LATE = 1'b1} mach_e;

  // wait T-states for step k of the 8-step pattern
  function automatic logic [2:0] step_delay(input mach_e mach, input logic [2:0] k);
    if (mach == MACH_EARLY) return (k < 3'd6) ? 3'd6 - k : 3'd0;
    if (k == 3'd0) return 3'd1;
    if (k == 3'd1) return 3'd0;
    return 3'(4'd9 - {1'b0, k});
  endfunction
endpackage

// File: rtl/frame_pos_ctr.sv
module frame_pos_ctr #(
  parameter int LINE_T      = 228,
  parameter int FRAME_LINES = 311,
  parameter int TW          = 8,
  parameter int LW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  output logic [TW-1:0] t_o,
  output logic [LW-1:0] line_o
);
  localparam logic [TW-1:0] T_LAST = TW'(LINE_T - 1);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES - 1);

  logic [TW-1:0] t_q;
  logic [LW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q    <= '0;
      line_q <= '0;
    end else if (ce_i) begin
      if (t_q == T_LAST) begin
        t_q    <= '0;
        line_q <= (line_q == L_LAST) ? '0 : line_q + 1'b1;
      end else begin
        t_q <= t_q + 1'b1;
      end
    end
  end

  assign t_o    = t_q;
  assign line_o = line_q;
endmodule

// File: rtl/pos_lag.sv
module pos_lag #(
  parameter int LINE_T      = 228,
  parameter int FRAME_LINES = 311,
  parameter int TW          = 8,
  parameter int LW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [TW-1:0] t_i,
  input  logic [LW-1:0] line_i,
  output logic [TW-1:0] t_o,
  output logic [LW-1:0] line_o
);
  // previous position; reset value is the last T-state of the frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_o    <= TW'(LINE_T - 1);
      line_o <= LW'(FRAME_LINES - 1);
    end else if (ce_i) begin
      t_o    <= t_i;
      line_o <= line_i;
    end
  end
endmodule

// File: rtl/contend_window.sv
module contend_window
  import contention_pkg::*;
#(
  parameter mach_e MACH      = MACH_EARLY,
  parameter int    START     = 5,
  parameter int    WIN       = 128,
  parameter int    PIC_LINE  = 63,
  parameter int    PIC_LINES = 192,
  parameter int    TW        = 8,
  parameter int    LW        = 9
) (
  input  logic [TW-1:0] t_i,
  input  logic [LW-1:0] line_i,
  output logic [2:0]    delay_o
);
  localparam logic [TW-1:0] T_LO = TW'(START);
  localparam logic [TW-1:0] T_HI = TW'(START + WIN);
  localparam logic [LW-1:0] L_LO = LW'(PIC_LINE);
  localparam logic [LW-1:0] L_HI = LW'(PIC_LINE + PIC_LINES);

  logic [TW-1:0] off;
  logic          in_win;

  always_comb begin
    off     = t_i - T_LO;
    in_win  = (line_i >= L_LO) && (line_i < L_HI) && (t_i >= T_LO) && (t_i < T_HI);
    delay_o = in_win ? step_delay(MACH, off[2:0]) : 3'd0;
  end
endmodule

// File: rtl/contention_gen.sv
module contention_gen
  import contention_pkg::*;
#(
  parameter int LINE_T      = 228,
  parameter int FRAME_LINES = 311,
  parameter int PIC_LINE    = 63,
  parameter int PIC_LINES   = 192,
  parameter int IRQ_LEN     = 32,
  parameter int START_EARLY = 5,
  parameter int WIN_EARLY   = 128,
  parameter int START_LATE  = 9,
  parameter int WIN_LATE    = 130,
  localparam int TW = $clog2(LINE_T),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          mode_i,
  input  logic          shift_i,
  input  logic          req_i,
  input  logic          contended_i,
  output logic [2:0]    delay_o,
  output logic          irq_o,
  output logic [LW-1:0] line_o,
  output logic [TW-1:0] tstate_o
);
  localparam logic [TW-1:0] IRQ_T = TW'(IRQ_LEN);

  logic [TW-1:0] cur_t, lag_t, eff_t;
  logic [LW-1:0] cur_line, lag_line, eff_line;
  logic [2:0]    win_delay [2];

  frame_pos_ctr #(.LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES), .TW(TW), .LW(LW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .t_o(cur_t), .line_o(cur_line)
  );

  pos_lag #(.LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES), .TW(TW), .LW(LW)) u_lag (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .t_i(cur_t), .line_i(cur_line),
    .t_o(lag_t), .line_o(lag_line)
  );

  assign eff_t    = shift_i ? lag_t : cur_t;
  assign eff_line = shift_i ? lag_line : cur_line;

  for (genvar m = 0; m < 2; m++) begin : g_mach
    contend_window #(
      .MACH     (m == 0 ? MACH_EARLY : MACH_LATE),
      .START    (m == 0 ? START_EARLY : START_LATE),
      .WIN      (m == 0 ? WIN_EARLY : WIN_LATE),
      .PIC_LINE (PIC_LINE),
      .PIC_LINES(PIC_LINES),
      .TW       (TW),
      .LW       (LW)
    ) u_win (
      .t_i(eff_t), .line_i(eff_line), .delay_o(win_delay[m])
    );
  end

  assign delay_o  = (req_i && contended_i) ? win_delay[mode_i] : 3'd0;
  assign irq_o    = (eff_line == '0) && (eff_t < IRQ_T);
  assign line_o   = cur_line;
  assign tstate_o = cur_t;
endmodule

// File: rtl/contention_chk.sv
module contention_chk #(
  parameter int LINE_T      = 228,
  parameter int FRAME_LINES = 311,
  parameter int PIC_LINE    = 63,
  parameter int IRQ_LEN     = 32,
  parameter int TW          = 8,
  parameter int LW          = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_i,
  input logic          shift_i,
  input logic          req_i,
  input logic          contended_i,
  input logic [2:0]    delay_o,
  input logic          irq_o,
  input logic [LW-1:0] line_o,
  input logic [TW-1:0] tstate_o
);
  localparam logic [TW-1:0] T_LAST = TW'(LINE_T - 1);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES - 1);
  localparam logic [LW-1:0] L_QUIET = LW'(PIC_LINE - 1);
  localparam logic [TW-1:0] IRQ_T = TW'(IRQ_LEN);

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o <= T_LAST) && (line_o <= L_LAST));

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && tstate_o == T_LAST) |=> (tstate_o == '0));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(tstate_o) && $stable(line_o)));

  p_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && line_o == '0 && tstate_o < IRQ_T) |-> irq_o);

  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o < L_QUIET) |-> (delay_o == 3'd0));

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && contended_i) |-> (delay_o == 3'd0));
endmodule

bind contention_gen contention_chk #(
  .LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES), .PIC_LINE(PIC_LINE),
  .IRQ_LEN(IRQ_LEN), .TW(TW), .LW(LW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .shift_i(shift_i), .req_i(req_i),
  .contended_i(contended_i), .delay_o(delay_o), .irq_o(irq_o), .line_o(line_o),
  .tstate_o(tstate_o)
);

// File: tb/sim_contention_gen.sv
module sim_contention_gen;
  localparam int FRAME = 70908;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_i = 1'b0, mode_i = 1'b0, shift_i = 1'b0, req_i = 1'b0, contended_i = 1'b0;
  logic [2:0] delay_o;
  logic       irq_o;
  logic [8:0] line_o;
  logic [7:0] tstate_o;

  int n_checks = 0;
  int n_fail   = 0;
  int n_pulse  = 0;
  int cyc      = 0;
  bit done     = 0;

  always #4 clk_i = ~clk_i;

  contention_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .mode_i(mode_i), .shift_i(shift_i),
    .req_i(req_i), .contended_i(contended_i), .delay_o(delay_o), .irq_o(irq_o),
    .line_o(line_o), .tstate_o(tstate_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (pulse %0d)", tag, what, act, exp, n_pulse);
    end
  endtask

  function automatic int exp_delay(input bit md, input int t, input int ln);
    int k;
    if (ln < 63 || ln > 254) return 0;
    if (!md) begin
      if (t < 5 || t > 132) return 0;
      k = (t - 5) % 8;
      return (k < 6) ? 6 - k : 0;
    end
    if (t < 9 || t > 138) return 0;
    k = (t - 9) % 8;
    if (k == 0) return 1;
    if (k == 1) return 0;
    return 9 - k;
  endfunction

  task automatic check_all(input bit after_idle);
    int p, e, et, el, d;
    string ctag, dtag, itag;
    p  = n_pulse % FRAME;
    e  = shift_i ? (p + FRAME - 1) % FRAME : p;
    et = e % 228;
    el = e / 228;
    ctag = after_idle ? "R2" : "R1";
    check(ctag, "tstate", int'(tstate_o), p % 228);
    check(ctag, "line", int'(line_o), p / 228);
    d = exp_delay(mode_i, et, el);
    if (!(req_i && contended_i)) begin
      dtag = "R7";
      d = 0;
    end else if (shift_i) dtag = "R8";
    else if (d == 0 && exp_delay(~mode_i, et, el) == 0 &&
             (el < 63 || el > 254 || et < 5 || et > 138)) dtag = "R6";
    else dtag = mode_i ? "R5" : "R4";
    check(dtag, "delay", int'(delay_o), d);
    itag = shift_i ? "R8" : "R3";
    check(itag, "irq", int'(irq_o), (el == 0 && et < 32) ? 1 : 0);
  endtask

  task automatic run_phase(input bit md, input int steps, input int shift_sel);
    bit idle = 0;
    for (int i = 0; i < steps; i++) begin
      @(negedge clk_i);
      mode_i      = md;
      shift_i     = (shift_sel == 0) ? 1'b0 :
                    (shift_sel == 1) ? (i >= 60000) : ((i / 5000) % 2 == 1);
      req_i       = (i % 7 != 3);
      contended_i = (i % 11 != 5);
      #1;
      check_all(idle);
      ce_i = (i % 997 != 500);
      idle = !ce_i;
      @(posedge clk_i);
      if (ce_i) n_pulse++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    // reset state, R1 and R3
    check("R1", "reset tstate", int'(tstate_o), 0);
    check("R1", "reset line", int'(line_o), 0);
    check("R3", "reset irq", int'(irq_o), 1);
    check("R7", "reset delay", int'(delay_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_phase(1'b0, FRAME + 60, 1);
    run_phase(1'b1, FRAME + 60, 2);
    done = 1;
  end

  initial begin
    while (!done && cyc < 190000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule